// File: doc/BRIEF.md
# Keyboard/Mouse Host Mailbox

This block is the host-facing mailbox of a legacy keyboard and mouse controller. The host reaches it through two byte-wide I/O ports: a data port and a command/status port. Any host write to either port lands in a single input buffer. An input-full flag is raised, and a port flag records which port carried the byte. On the other side, an embedded core takes that byte through a valid/ready handshake and returns answers by writing an output byte through a keyboard path or a mouse path.

While the output buffer holds a byte, the matching host interrupt line is held high: the keyboard line for keyboard data, the mouse line for mouse data. Each line has its own enable. A host read of the data port drains the buffer, drops the interrupt and, if enabled, pulses an output-empty interrupt to the core. The core also gets a level interrupt while the input buffer is full. The three flags owned by the hardware cannot be changed by core writes to the status byte. The core may set or clear every other status bit.

The core-side input stream is `in_valid`/`in_ready`. `in_valid` equals the input-full flag. A byte is consumed in any cycle where both are high. The stream has no back-pressure toward the host: a host write while the buffer is full overwrites it. Core output writes are always accepted and have no ready signal.

Top module: `kbd_mbox`

## Requirements
- R1: A host write (`host_wr`) loads `host_wdata` into the input buffer and sets the input-full flag at the next edge. The port flag is set to `host_port` (0 = data port, 1 = command port). A write while the buffer is full overwrites the byte.
- R2: `in_valid` equals the input-full flag and `in_data` shows the buffered byte. A cycle with `in_valid` and `in_ready` high clears the flag at the next edge, unless a host write arrives in the same cycle, in which case the flag stays set with the new byte.
- R3: `core_kb_wr` loads `core_wdata` into the output buffer, sets the output-full flag and marks the byte as keyboard data. `irq_kb` is high while the flag is set, the byte is keyboard data and `en_kb_irq` is 1.
- R4: `core_ms_wr` does the same for mouse data and drives `irq_ms` (gated by `en_ms_irq`). If both write strobes are high in one cycle, the keyboard write wins.
- R5: A host read (`host_rd`) with `host_port`=0 shows the output byte on `host_rdata` in the same cycle. It clears the output-full flag at the next edge, which drops the active host IRQ.
- R6: A host read with `host_port`=1 shows the status byte in the same cycle and changes no state. The status byte layout is: bit 0 = output full, bit 1 = input full, bit 3 = port flag, and bits 2 and 7..4 are the core-owned bits. `core_status` shows the same byte at all times.
- R7: `force_clr` clears the output-full flag at the next edge. A core output write in the same cycle takes priority.
- R8: `core_sts_wr` writes bits 2 and 7..4 of the status byte from `core_sts_wdata`. Bits 0, 1 and 3 are left unchanged.
- R9: When a data-port host read empties a full output buffer and `en_obe_irq` is 1, `core_obe_irq` is high for exactly the one cycle after that edge. A read while the buffer is already empty gives no pulse.
- R10: `core_ibf_irq` is high exactly while the input-full flag is set and `en_ibf_irq` is 1.
- R11: A core output write while the output-full flag is set replaces the byte and keeps the flag set.
- R12: Both host IRQ lines are level, active high, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_port | input | 1 | 0 = data port, 1 = command/status port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| in_valid | output | 1 | Input byte available to core |
| in_ready | input | 1 | Core accepts input byte |
| in_data | output | 8 | Buffered input byte |
| in_is_cmd | output | 1 | Port flag of the buffered byte |
| core_kb_wr | input | 1 | Core keyboard output write |
| core_ms_wr | input | 1 | Core mouse output write |
| core_wdata | input | 8 | Core output byte |
| force_clr | input | 1 | Core force-clear of output-full flag |
| core_sts_wr | input | 1 | Core status write strobe |
| core_sts_wdata | input | 8 | Core status write value |
| core_status | output | 8 | Status byte |
| en_kb_irq | input | 1 | Keyboard IRQ enable |
| en_ms_irq | input | 1 | Mouse IRQ enable |
| en_ibf_irq | input | 1 | Input-full core interrupt enable |
| en_obe_irq | input | 1 | Output-empty core interrupt enable |
| irq_kb | output | 1 | Keyboard host IRQ |
| irq_ms | output | 1 | Mouse host IRQ |
| core_ibf_irq | output | 1 | Input-full core interrupt |
| core_obe_irq | output | 1 | Output-empty core interrupt pulse |

## Verification
Read data on `host_rdata` is combinational, so it is sampled mid-cycle while the read strobe is still applied, before the edge that acts on it. Each strobe changes flags at the next rising edge. Flags, status and IRQ lines are therefore checked at the falling edge that follows, exactly one register stage later. The output-empty pulse is checked at that same falling edge and again one cycle later, to prove it lasts a single cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned STS_W   = 8;
  localparam int unsigned OBF_POS = 0;
  localparam int unsigned IBF_POS = 1;
  localparam int unsigned A2_POS  = 3;
  localparam logic [STS_W-1:0] HW_MASK =
    STS_W'((1 << OBF_POS) | (1 << IBF_POS) | (1 << A2_POS));
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic { SRC_KB = 1'b0, SRC_MS = 1'b1 } out_src_e;
endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_port,
  input  logic [DW-1:0] host_wdata,
  input  logic          in_ready,
  output logic          ibf,
  output logic          a2,
  output logic [DW-1:0] in_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf     <= 1'b0;
      a2      <= 1'b0;
      in_data <= '0;
    end else if (host_wr) begin
      ibf     <= 1'b1;
      a2      <= host_port;
      in_data <= host_wdata;
    end else if (in_ready && ibf) begin
      ibf <= 1'b0;
    end
  end

  // R1
  host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (ibf && (a2 == $past(host_port)) && (in_data == $past(host_wdata))));

  // R2
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && in_ready && !host_wr) |=> !ibf);
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf #(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_kb_wr,
  input  logic            core_ms_wr,
  input  logic [DW-1:0]   core_wdata,
  input  logic            force_clr,
  input  logic            host_drain,
  input  logic            en_obe_irq,
  output logic            obf,
  output kbc_pkg::out_src_e src,
  output logic [DW-1:0]   out_data,
  output logic            obe_pulse
);
  import kbc_pkg::*;

  logic any_wr;
  assign any_wr = core_kb_wr | core_ms_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf      <= 1'b0;
      src      <= SRC_KB;
      out_data <= '0;
    end else if (any_wr) begin
      obf      <= 1'b1;
      src      <= core_kb_wr ? SRC_KB : SRC_MS;
      out_data <= core_wdata;
    end else if (force_clr || host_drain) begin
      obf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) obe_pulse <= 1'b0;
    else        obe_pulse <= en_obe_irq && host_drain && obf && !any_wr;
  end

  // R3
  kb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_kb_wr |=> (obf && src == SRC_KB && out_data == $past(core_wdata)));

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_drain && !any_wr) |=> !obf);

  // R9
  obe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    obe_pulse |=> !obe_pulse);
endmodule

// File: rtl/kbc_status.sv
module kbc_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_sts_wr,
  input  logic [kbc_pkg::STS_W-1:0] core_sts_wdata,
  input  logic       obf,
  input  logic       ibf,
  input  logic       a2,
  output logic [kbc_pkg::STS_W-1:0] status
);
  import kbc_pkg::*;

  logic [STS_W-1:0] free_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           free_q <= '0;
    else if (core_sts_wr) free_q <= core_sts_wdata & ~HW_MASK;
  end

  always_comb begin
    status          = free_q;
    status[OBF_POS] = obf;
    status[IBF_POS] = ibf;
    status[A2_POS]  = a2;
  end
endmodule

// File: rtl/kbd_mbox.sv
module kbd_mbox #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_port,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          in_valid,
  input  logic          in_ready,
  output logic [DW-1:0] in_data,
  output logic          in_is_cmd,
  input  logic          core_kb_wr,
  input  logic          core_ms_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          force_clr,
  input  logic          core_sts_wr,
  input  logic [7:0]    core_sts_wdata,
  output logic [7:0]    core_status,
  input  logic          en_kb_irq,
  input  logic          en_ms_irq,
  input  logic          en_ibf_irq,
  input  logic          en_obe_irq,
  output logic          irq_kb,
  output logic          irq_ms,
  output logic          core_ibf_irq,
  output logic          core_obe_irq
);
  import kbc_pkg::*;

  logic               ibf, a2, obf;
  out_src_e           src;
  logic [DW-1:0]      out_data;
  logic [STS_W-1:0]   status;
  logic               host_drain;
  logic [NUM_SRC-1:0] irq_en, irq_vec;

  assign host_drain = host_rd && !host_port;

  kbc_in_buf #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
    .host_wdata(host_wdata), .in_ready(in_ready),
    .ibf(ibf), .a2(a2), .in_data(in_data)
  );

  kbc_out_buf #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .core_kb_wr(core_kb_wr), .core_ms_wr(core_ms_wr),
    .core_wdata(core_wdata), .force_clr(force_clr), .host_drain(host_drain),
    .en_obe_irq(en_obe_irq), .obf(obf), .src(src), .out_data(out_data),
    .obe_pulse(core_obe_irq)
  );

  kbc_status u_sts (
    .clk(clk), .rst_n(rst_n), .core_sts_wr(core_sts_wr),
    .core_sts_wdata(core_sts_wdata), .obf(obf), .ibf(ibf), .a2(a2),
    .status(status)
  );

  assign irq_en = {en_ms_irq, en_kb_irq};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_irq
    assign irq_vec[g] = obf && (int'(src) == g) && irq_en[g];
  end

  assign irq_kb       = irq_vec[SRC_KB];
  assign irq_ms       = irq_vec[SRC_MS];
  assign in_valid     = ibf;
  assign in_is_cmd    = a2;
  assign core_status  = status;
  assign core_ibf_irq = ibf && en_ibf_irq;
  assign host_rdata   = host_port ? DW'(status) : out_data;

  // R12
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_kb, irq_ms}));

  // R6
  sts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_port && !host_wr && !in_ready && !core_kb_wr && !core_ms_wr
     && !force_clr && !core_sts_wr) |=> $stable(core_status));
endmodule

// File: tb/test_kbd_mbox.sv
module test_kbd_mbox;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0, host_port = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic       in_valid, in_ready = 0, in_is_cmd;
  logic [7:0] in_data;
  logic       core_kb_wr = 0, core_ms_wr = 0, force_clr = 0, core_sts_wr = 0;
  logic [7:0] core_wdata = 0, core_sts_wdata = 0, core_status;
  logic       en_kb_irq = 1, en_ms_irq = 1, en_ibf_irq = 1, en_obe_irq = 1;
  logic       irq_kb, irq_ms, core_ibf_irq, core_obe_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbd_mbox i_kbd_mbox (.*);

  localparam logic [3:0] OP_HWR = 1, OP_HRD = 2, OP_CIN = 3, OP_KB = 4,
                         OP_MS = 5, OP_STW = 6, OP_FCLR = 7;

  function automatic logic [31:0] vec(logic [3:0] op, logic sel, logic [7:0] d,
                                      logic [7:0] ev, logic [7:0] st, logic [1:0] irq);
    return {op, sel, d, ev, st, irq, 1'b0};
  endfunction

  localparam int NV = 15;
  localparam logic [31:0] TBL [NV] = '{
    vec(OP_HWR, 0, 8'h11, 8'h00, 8'h02, 2'b00), // R1 data port
    vec(OP_CIN, 0, 8'h00, 8'h11, 8'h00, 2'b00), // R2
    vec(OP_HWR, 1, 8'hAB, 8'h00, 8'h0A, 2'b00), // R1 command port
    vec(OP_CIN, 0, 8'h00, 8'hAB, 8'h08, 2'b00), // R2
    vec(OP_KB,  0, 8'h5A, 8'h00, 8'h09, 2'b01), // R3
    vec(OP_HRD, 1, 8'h00, 8'h09, 8'h09, 2'b01), // R6
    vec(OP_HRD, 0, 8'h00, 8'h5A, 8'h08, 2'b00), // R5
    vec(OP_MS,  0, 8'h77, 8'h00, 8'h09, 2'b10), // R4
    vec(OP_KB,  0, 8'h33, 8'h00, 8'h09, 2'b01), // R11
    vec(OP_HRD, 0, 8'h00, 8'h33, 8'h08, 2'b00), // R5
    vec(OP_STW, 0, 8'hFF, 8'h00, 8'hFC, 2'b00), // R8
    vec(OP_STW, 0, 8'h00, 8'h00, 8'h08, 2'b00), // R8
    vec(OP_KB,  0, 8'h01, 8'h00, 8'h09, 2'b01), // R3
    vec(OP_FCLR,0, 8'h00, 8'h00, 8'h08, 2'b00), // R7
    vec(OP_HWR, 0, 8'h42, 8'h00, 8'h02, 2'b00)  // R1
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset status", core_status, 8'h00);
    chk("R12 reset irq", {6'd0, irq_ms, irq_kb}, 8'h00);
    chk("R2 reset valid", {7'd0, in_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      logic [7:0] d, ev, st;
      logic [1:0] irq;
      op = TBL[i][31:28];
      d  = TBL[i][26:19];
      ev = TBL[i][18:11];
      st = TBL[i][10:3];
      irq = TBL[i][2:1];
      host_port = TBL[i][27];
      host_wdata = d; core_wdata = d; core_sts_wdata = d;
      host_wr = (op == OP_HWR); host_rd = (op == OP_HRD);
      in_ready = (op == OP_CIN); core_kb_wr = (op == OP_KB);
      core_ms_wr = (op == OP_MS); core_sts_wr = (op == OP_STW);
      force_clr = (op == OP_FCLR);
      #5;
      if (op == OP_HRD) chk("R5/R6 host read", host_rdata, ev);
      if (op == OP_CIN) chk("R2 in_data", in_data, ev);
      @(negedge clk);
      host_wr = 0; host_rd = 0; in_ready = 0; core_kb_wr = 0;
      core_ms_wr = 0; core_sts_wr = 0; force_clr = 0;
      chk("R1/R3/R7/R8 status", core_status, st);
      chk("R12 irq lines", {6'd0, irq_ms, irq_kb}, {6'd0, irq});
    end

    // R10: input-full core interrupt follows flag and enable
    chk("R10 ibf irq on", {7'd0, core_ibf_irq}, 8'h01);
    en_ibf_irq = 0; #1;
    chk("R10 ibf irq gated", {7'd0, core_ibf_irq}, 8'h00);
    en_ibf_irq = 1;

    // R2: host write and core accept collide; write wins
    host_wr = 1; host_port = 1; host_wdata = 8'hC3; in_ready = 1;
    @(negedge clk);
    host_wr = 0; in_ready = 0;
    chk("R2 collision valid", {7'd0, in_valid}, 8'h01);
    chk("R2 collision data", in_data, 8'hC3);
    chk("R1 cmd flag", {7'd0, in_is_cmd}, 8'h01);

    // R9: drain produces a single-cycle output-empty pulse
    core_kb_wr = 1; core_wdata = 8'h9E;
    @(negedge clk);
    core_kb_wr = 0; host_rd = 1; host_port = 0;
    @(negedge clk);
    host_rd = 0;
    chk("R9 obe pulse", {7'd0, core_obe_irq}, 8'h01);
    @(negedge clk);
    chk("R9 obe pulse ends", {7'd0, core_obe_irq}, 8'h00);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    chk("R9 no pulse when empty", {7'd0, core_obe_irq}, 8'h00);

    // R12: keyboard IRQ gated by its enable while OBF held
    en_kb_irq = 0; core_kb_wr = 1; core_wdata = 8'h10;
    @(negedge clk);
    core_kb_wr = 0;
    chk("R12 kb irq gated", {7'd0, irq_kb}, 8'h00);
    chk("R3 obf while gated", {7'd0, core_status[0]}, 8'h01);
    en_kb_irq = 1; #1;
    chk("R12 kb irq enabled", {7'd0, irq_kb}, 8'h01);

    // R4: simultaneous writes, keyboard wins
    core_kb_wr = 1; core_ms_wr = 1; core_wdata = 8'h66;
    @(negedge clk);
    core_kb_wr = 0; core_ms_wr = 0;
    chk("R4 kb priority", {6'd0, irq_ms, irq_kb}, 8'h01);

    // R7: force clear loses to a same-cycle write
    force_clr = 1; core_ms_wr = 1; core_wdata = 8'h24;
    @(negedge clk);
    force_clr = 0; core_ms_wr = 0;
    chk("R7 write beats clear", {6'd0, irq_ms, irq_kb}, 8'h02);
    host_port = 0; #1;
    chk("R11 new byte", host_rdata, 8'h24);

    finish_run();
  end
endmodule